// File: doc/BRIEF.md
# Front-End Trigger Latency Buffer

This block models the digital back half of a detector readout chip. On every clock it stores the current channel hit vector into a circular latency memory. A level-1 accept command arrives as a short serial pattern on a single trigger line. When it does, the block fetches the hit vector that was stored a programmable number of clocks earlier. It tags that vector with a running event number and queues the pair in a small event buffer.

A serializer takes queued events in arrival order and sends each one as a fixed-length frame on a single data line, one bit per clock. A data-valid strobe stays high for the whole frame. Accepts that arrive while the event buffer is full are dropped, and a sticky overflow flag records the loss.

Two state machines control the block. The trigger decoder has three states:
- `DEC_IDLE` moves to `DEC_SAW1` on a 1.
- `DEC_SAW1` stays there on a 1 and moves to `DEC_SAW10` on a 0.
- `DEC_SAW10` returns to `DEC_SAW1` on a 1. On a 0 it fires the accept and returns to `DEC_IDLE`.

The serializer has three states:
- `SER_IDLE` moves to `SER_SHIFT` when the buffer holds an event. On that move it loads and pops the event.
- `SER_SHIFT` moves to `SER_GAP` after the last frame bit.
- `SER_GAP` returns to `SER_IDLE` after one clock.

Top module: `fe_trig_buffer`

## Requirements
- R1: While reset is asserted and directly after it, `ser_data`, `ser_valid` and `evq_overflow` are all 0.
- R2: An accept is recognized on the clock edge that samples the third bit of the sequence 1, 0, 0 on `l1_line`, one bit per edge. A 1 arriving where the second 0 is expected restarts the match. So 1,1,0,0 yields one accept, and 1,0,1,1,0,1,0,0 yields exactly one accept, on its final bit.
- R3: With `lat_cfg` = L in 1..255, the captured hit vector is the `hit_vec` value sampled L edges before the edge that recognized the accept. With L = 0 it is the value sampled 256 edges before.
- R4: Each frame is 48 bits, MSB first. Bits 47..32 carry the event number and bits 31..0 carry the hit vector. `ser_valid` stays high for exactly 48 consecutive clocks per frame.
- R5: When the buffer is empty and the serializer is idle, `ser_valid` is still low after the accept edge E. It is high after edge E+1, with the frame's bit 47 on `ser_data`.
- R6: The event number of an accept equals the number of accepts recognized since reset before it, modulo 2^16. Dropped accepts are counted too.
- R7: Frames leave in the order their accepts were recognized. Up to 4 events can wait while another frame is being sent.
- R8: An accept recognized while 4 events are waiting produces no frame. It sets `evq_overflow`, which then stays 1 until reset.
- R9: Between two frames, `ser_valid` is low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1_line | input | 1 | Serial trigger command line |
| hit_vec | input | 32 | Channel hit vector, sampled every clock |
| lat_cfg | input | 8 | Trigger latency in clocks (0 means 256) |
| ser_data | output | 1 | Serial frame data, MSB first |
| ser_valid | output | 1 | High while a frame bit is on `ser_data` |
| evq_overflow | output | 1 | Sticky flag: an accept was dropped |

## Verification
The bench builds the block with its default parameters: 32 hit channels, an 8-bit latency, a 256-entry ring, a 16-bit event number and a 4-deep event buffer. With a 256-entry ring, the latency wrap at L = 0 and the boundary at L = 255 can be reached within a few hundred clocks. With a 4-deep buffer, six back-to-back accepts are enough to fill it and force a drop. The gap in event numbers that follows a drop can then be observed.

// File: rtl/fe_trig_pkg.sv
package fe_trig_pkg;

    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_SAW1  = 2'd1,
        DEC_SAW10 = 2'd2
    } dec_state_t;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_GAP   = 2'd2
    } ser_state_t;

endpackage

// File: rtl/l1a_decoder.sv
module l1a_decoder
    import fe_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic accept
);

    dec_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_IDLE:  state_d = line_in ? DEC_SAW1 : DEC_IDLE;
            DEC_SAW1:  state_d = line_in ? DEC_SAW1 : DEC_SAW10;
            DEC_SAW10: state_d = line_in ? DEC_SAW1 : DEC_IDLE;
            default:   state_d = DEC_IDLE;
        endcase
    end

    always_comb begin
        accept = (state_q == DEC_SAW10) && !line_in;
    end

    // R2: an accept only ever follows the sampled bits 1, 0, 0
    p_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(line_in, 2) && !$past(line_in) && !line_in));

endmodule

// File: rtl/latency_ring.sv
module latency_ring #(
    parameter int HIT_W = 32,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HIT_W-1:0] wr_data,
    input  logic [LAT_W-1:0] delay,
    output logic [HIT_W-1:0] rd_data
);

    localparam int DEPTH = 1 << LAT_W;

    logic [HIT_W-1:0] ring [DEPTH];
    logic [LAT_W-1:0] wr_ptr;
    logic [LAT_W-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_ptr <= '0;
        else        wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        ring[wr_ptr] <= wr_data;
    end

    // delay 0 points at the slot about to be overwritten: the oldest entry
    always_comb begin
        rd_ptr  = wr_ptr - delay;
        rd_data = ring[rd_ptr];
    end

    // R3: the write pointer advances by one slot per clock
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_ptr == LAT_W'($past(wr_ptr) + 1'b1)));

endmodule

// File: rtl/event_fifo.sv
module event_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        do_wr   = wr_en && !full;
        do_rd   = rd_en && !empty;
        rd_data = store[rp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) store[wp] <= wr_data;
    end

    // R7: occupancy never exceeds the buffer depth
    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8: a write into a full buffer without a read leaves it full
    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> full);

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import fe_trig_pkg::*;
#(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_empty,
    input  logic [FRAME_W-1:0] q_data,
    output logic               q_pop,
    output logic               sd,
    output logic               sv
);

    localparam int BCW = $clog2(FRAME_W);

    ser_state_t         state_q, state_d;
    logic [FRAME_W-1:0] shreg;
    logic [BCW-1:0]     bit_cnt;
    logic               last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        last_bit = (bit_cnt == BCW'(FRAME_W - 1));
        state_d  = state_q;
        unique case (state_q)
            SER_IDLE:  state_d = q_empty ? SER_IDLE : SER_SHIFT;
            SER_SHIFT: state_d = last_bit ? SER_GAP : SER_SHIFT;
            SER_GAP:   state_d = SER_IDLE;
            default:   state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state_q == SER_IDLE && !q_empty) begin
            shreg   <= q_data;
            bit_cnt <= '0;
        end else if (state_q == SER_SHIFT) begin
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        q_pop = (state_q == SER_IDLE) && !q_empty;
        sv    = (state_q == SER_SHIFT);
        sd    = sv && shreg[FRAME_W-1];
    end

    // R4: a frame ends only after its last bit has been shown
    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sv) |-> ($past(bit_cnt) == BCW'(FRAME_W - 1)));

    // R9: the strobe stays low on the clock after a frame ends
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sv) |=> !sv);

endmodule

// File: rtl/fe_trig_buffer.sv
module fe_trig_buffer #(
    parameter int HIT_W     = 32,
    parameter int LAT_W     = 8,
    parameter int EVT_W     = 16,
    parameter int EVQ_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1_line,
    input  logic [HIT_W-1:0] hit_vec,
    input  logic [LAT_W-1:0] lat_cfg,
    output logic             ser_data,
    output logic             ser_valid,
    output logic             evq_overflow
);

    localparam int FRAME_W = EVT_W + HIT_W;

    logic               accept;
    logic [HIT_W-1:0]   past_hits;
    logic [EVT_W-1:0]   evt_num;
    logic               q_full, q_empty, q_pop;
    logic [FRAME_W-1:0] q_head;
    logic               ovf_q;

    l1a_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (l1_line),
        .accept  (accept)
    );

    latency_ring #(.HIT_W(HIT_W), .LAT_W(LAT_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (hit_vec),
        .delay   (lat_cfg),
        .rd_data (past_hits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_num <= '0;
            ovf_q   <= 1'b0;
        end else if (accept) begin
            evt_num <= evt_num + 1'b1;
            if (q_full) ovf_q <= 1'b1;
        end
    end

    event_fifo #(.W(FRAME_W), .DEPTH(EVQ_DEPTH)) u_evq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data ({evt_num, past_hits}),
        .rd_en   (q_pop),
        .rd_data (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    frame_serializer #(.FRAME_W(FRAME_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_empty (q_empty),
        .q_data  (q_head),
        .q_pop   (q_pop),
        .sd      (ser_data),
        .sv      (ser_valid)
    );

    assign evq_overflow = ovf_q;

    // R8: once set, the overflow flag holds until reset
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evq_overflow |=> evq_overflow);

    // R6: the event number steps exactly on recognized accepts
    p_evt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (evt_num == $past(evt_num)));

endmodule

// File: tb/fe_trig_buffer_tb.sv
module fe_trig_buffer_tb;

    localparam int HIT_W = 32;
    localparam int LAT_W = 8;
    localparam int FW    = 48;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             l1_line = 1'b0;
    logic [HIT_W-1:0] hit_vec = '0;
    logic [LAT_W-1:0] lat_cfg = 8'd10;
    logic             ser_data, ser_valid, evq_overflow;

    fe_trig_buffer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .l1_line      (l1_line),
        .hit_vec      (hit_vec),
        .lat_cfg      (lat_cfg),
        .ser_data     (ser_data),
        .ser_valid    (ser_valid),
        .evq_overflow (evq_overflow)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int acc = 0;

    logic [FW-1:0] exp_f [64];
    logic [FW-1:0] got_f [64];
    int exp_n = 0;
    int got_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pat(input int n);
        logic [15:0] k;
        k = n[15:0];
        return {k ^ 16'hC35A, ~k};
    endfunction

    // hit vector seen at edge k is pat(k)
    always @(negedge clk) hit_vec <= pat(cyc + 1);

    // frame collector
    logic [FW-1:0] shr = '0;
    int  nbits = 0;
    bit  prev_v = 1'b0;
    always @(negedge clk) begin
        if (ser_valid) begin
            shr = {shr[FW-2:0], ser_data};
            nbits++;
        end else if (prev_v) begin
            if (nbits != FW) begin
                n_chk++; n_bad++;
                $display("FAIL R4 frame length act=%0d exp=%0d", nbits, FW);
            end
            if (got_n < 64) got_f[got_n] = shr;
            got_n++;
            nbits = 0;
        end
        prev_v = ser_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // sends bits MSB first; returns the edge index sampling the last bit
    task automatic send_seq(input logic [7:0] bits, input int n, output int e);
        e = 0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            l1_line = bits[i];
            e = cyc + 1;
        end
        @(negedge clk);
        l1_line = 1'b0;
    endtask

    task automatic expect_event(input int e, input bit kept);
        int d;
        d = (lat_cfg == 0) ? 256 : int'(lat_cfg);
        if (kept && exp_n < 64) begin
            exp_f[exp_n] = {acc[15:0], pat(e - d)};
            exp_n++;
        end
        acc++;
    endtask

    task automatic drain(input int start, input string tag);
        int guard = 0;
        while (got_n < exp_n && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (120) @(negedge clk);
        chk(got_n == exp_n, {tag, " frame count"}, 64'(got_n), 64'(exp_n));
        for (int i = start; i < exp_n && i < 64; i++)
            chk(got_f[i] == exp_f[i], {tag, " frame content"}, 64'(got_f[i]), 64'(exp_f[i]));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!ser_valid && !ser_data && !evq_overflow, "R1 in reset",
            {ser_valid, ser_data, evq_overflow}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ser_valid && !ser_data && !evq_overflow, "R1 after reset",
            {ser_valid, ser_data, evq_overflow}, 0);
        repeat (300) @(negedge clk);
    endtask

    task automatic t_start_timing;
        int e, s;
        s = exp_n;
        lat_cfg = 8'd10;
        // one accept, timing as in R5
        @(negedge clk); l1_line = 1'b1;
        @(negedge clk); l1_line = 1'b0;
        @(negedge clk); l1_line = 1'b0; e = cyc + 1;
        expect_event(e, 1'b1);
        @(negedge clk); l1_line = 1'b0;
        chk(!ser_valid, "R5 low after accept edge", 64'(ser_valid), 0);
        @(negedge clk);
        chk(ser_valid, "R5 high one edge later", 64'(ser_valid), 1);
        chk(ser_data == exp_f[s][FW-1], "R5 first bit is bit 47",
            64'(ser_data), 64'(exp_f[s][FW-1]));
        drain(s, "R3 R4 R6 latency 10");
    endtask

    task automatic t_latency(input logic [7:0] l, input string tag);
        int e, s;
        s = exp_n;
        @(negedge clk); lat_cfg = l;
        send_seq(8'b100, 3, e);
        expect_event(e, 1'b1);
        drain(s, tag);
    endtask

    task automatic t_patterns;
        int e, s;
        s = exp_n;
        send_seq(8'b1100, 4, e);
        expect_event(e, 1'b1);
        drain(s, "R2 pattern 1100");
        s = exp_n;
        send_seq(8'b10110100, 8, e);
        expect_event(e, 1'b1);
        drain(s, "R2 pattern 10110100");
    endtask

    task automatic t_order;
        int e, s;
        s = exp_n;
        lat_cfg = 8'd20;
        for (int i = 0; i < 3; i++) begin
            send_seq(8'b100, 3, e);
            expect_event(e, 1'b1);
        end
        drain(s, "R7 R9 three queued");
        chk(!evq_overflow, "R8 no overflow at 3", 64'(evq_overflow), 0);
    endtask

    task automatic t_overflow;
        int e, s;
        s = exp_n;
        lat_cfg = 8'd40;
        // first is sent at once, four wait, sixth is dropped
        for (int i = 0; i < 6; i++) begin
            send_seq(8'b100, 3, e);
            expect_event(e, i < 5);
        end
        @(negedge clk);
        chk(evq_overflow, "R8 overflow set", 64'(evq_overflow), 1);
        drain(s, "R7 R8 full buffer");
        chk(evq_overflow, "R8 overflow sticky", 64'(evq_overflow), 1);
        s = exp_n;
        send_seq(8'b100, 3, e);
        expect_event(e, 1'b1);
        drain(s, "R6 number counts the drop");
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_start_timing();
        t_latency(8'd1,   "R3 latency 1");
        t_latency(8'd255, "R3 latency 255");
        t_latency(8'd0,   "R3 latency 0 means 256");
        t_patterns();
        t_order();
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule